// File: doc/BRIEF.md
# Burst Read Fetch Engine

This block reads one transmit frame from external memory through a Wishbone master port and stores every returned word in a small local FIFO. A descriptor engine supplies a start pointer and a frame length in bytes, then pulses a start request. The block turns the length into a count of 32-bit words and starts from the word-aligned pointer. It then runs a block read in which the cycle and strobe lines stay high from the first beat to the last. After each acknowledge it presents the next word address on the following clock.

The FIFO's read side is exposed so that a downstream transmitter can drain it. When the FIFO cannot take another word, the engine completes the beat in flight and closes the bus cycle. Once space is available it opens a new cycle at the next address. A bus error ends the fetch and pulses an error flag. A clean finish pulses a done flag.

Top module: `wb_burst_fetch`

## Requirements
- R1: After reset, cycle, strobe, busy, done and error are low and the FIFO reports empty.
- R2: The fetch reads ceil(length/4) words. The first address is the pointer with bits 1:0 cleared, and each later address is 4 higher than the one before.
- R3: Once a cycle is open, cycle and strobe stay high together on every clock until the final acknowledge, an error, or a pause. The address changes on the clock after each acknowledge.
- R4: Write enable is always 0 and byte select is always 4'b1111.
- R5: Each acknowledged word enters the FIFO. The FIFO read port presents the oldest word first, and asserting the read enable removes it.
- R6: If an acknowledge arrives while fewer than two FIFO entries are free and words remain, cycle and strobe go low on the next clock. A new cycle opens at the next address on the clock after at least one entry is free.
- R7: An error response with the strobe high drops cycle and strobe on the next clock and pulses the error output for one cycle. It pushes no data and raises no done pulse.
- R8: Done is high for exactly the one clock after the final acknowledge, and cycle is low in that clock.
- R9: A start with a length of zero produces a done pulse on the next clock and no bus cycle.
- R10: A start request while busy is high is ignored, and the fetch in progress continues unchanged.
- R11: With the FIFO not full, cycle rises on the second clock after the start request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request (one cycle) |
| buf_ptr_i | input | AW | Frame pointer in bytes |
| byte_len_i | input | LW | Frame length in bytes |
| busy_o | output | 1 | Fetch in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle bus error pulse |
| wb_cyc_o | output | 1 | Bus cycle |
| wb_stb_o | output | 1 | Bus strobe |
| wb_we_o | output | 1 | Write enable, always 0 |
| wb_sel_o | output | 4 | Byte select, always 1111 |
| wb_adr_o | output | AW | Word address |
| wb_dat_i | input | 32 | Read data |
| wb_ack_i | input | 1 | Acknowledge |
| wb_err_i | input | 1 | Error response |
| fifo_rd_en_i | input | 1 | FIFO read enable |
| fifo_rd_data_o | output | 32 | Oldest FIFO word |
| fifo_empty_o | output | 1 | FIFO empty |

## Verification
A wrong word counter or address register shows up on the address bus on the clock after the acknowledge where it goes wrong, or as a done pulse that comes early or late. A wrong FIFO room check shows up within one beat, as strobe held high when it should have dropped or as an overwritten word at the read port. State-machine faults appear on the first clock in which cycle, strobe, done or error differs from a reference model that runs alongside the design. The bench compares every output on every clock, so each such fault is caught in the cycle it reaches the ports.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  localparam int WORD_W = 32;
  localparam int WORD_BYTES = WORD_W / 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_BUS  = 2'd2
  } fetch_state_e;
endpackage

// File: rtl/fetch_fifo.sv
module fetch_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic          empty,
  output logic          room1,
  output logic          room2
);
  localparam int PW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LVW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0]  LAST_PTR = PW'(DEPTH - 1);
  localparam logic [LVW-1:0] LIM1     = LVW'(DEPTH - 1);

  logic [DW-1:0]  mem [DEPTH];
  logic [PW-1:0]  wr_ptr, wr_ptr_n, rd_ptr, rd_ptr_n;
  logic [LVW-1:0] level, level_n;
  logic           pop_v;

  assign pop_v = pop && (level != '0);
  assign empty = (level == '0);
  assign room1 = (level <= LIM1);
  assign room2 = (level < LIM1);
  assign rdata = mem[rd_ptr];

  always_comb begin
    wr_ptr_n = wr_ptr;
    rd_ptr_n = rd_ptr;
    level_n  = level;
    if (push) wr_ptr_n = (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
    if (pop_v) rd_ptr_n = (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
    case ({push, pop_v})
      2'b10:   level_n = level + 1'b1;
      2'b01:   level_n = level - 1'b1;
      default: level_n = level;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      wr_ptr <= wr_ptr_n;
      rd_ptr <= rd_ptr_n;
      level  <= level_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> room1);
endmodule

// File: rtl/fetch_addr_seq.sv
module fetch_addr_seq #(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          adv,
  input  logic [AW-1:0] base,
  input  logic [LW-1:0] len,
  output logic [AW-1:0] adr,
  output logic          last,
  output logic          zero
);
  import fetch_pkg::*;
  localparam int CW = LW - 1;
  localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

  logic [CW-1:0] rem, rem_n;
  logic [AW-1:0] adr_n;
  logic [LW:0]   rounded;
  logic [CW-1:0] words;

  assign rounded = {1'b0, len} + (LW+1)'(WORD_BYTES - 1);
  assign words   = rounded[LW:2];
  assign zero    = (len == '0);
  assign last    = (rem == CW'(1));

  always_comb begin
    adr_n = adr;
    rem_n = rem;
    if (load) begin
      adr_n = {base[AW-1:2], 2'b00};
      rem_n = words;
    end else if (adv) begin
      adr_n = adr + STEP;
      rem_n = rem - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adr <= '0;
      rem <= '0;
    end else begin
      adr <= adr_n;
      rem <= rem_n;
    end
  end

  // R2
  adr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load) |=> (adr == $past(adr) + STEP));
endmodule

// File: rtl/fetch_ctrl.sv
module fetch_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic zero_len,
  input  logic ack,
  input  logic err_in,
  input  logic last,
  input  logic room1,
  input  logic room2,
  output logic cyc,
  output logic load,
  output logic adv,
  output logic push,
  output logic done,
  output logic err_out,
  output logic busy
);
  import fetch_pkg::*;

  fetch_state_e state, state_n;
  logic done_n, err_n;
  logic in_bus, ack_v, err_v;

  assign in_bus = (state == ST_BUS);
  assign err_v  = in_bus && err_in;
  assign ack_v  = in_bus && ack && !err_in;
  assign cyc    = in_bus;
  assign busy   = (state != ST_IDLE);
  assign load   = (state == ST_IDLE) && start;
  assign adv    = ack_v;
  assign push   = ack_v;

  always_comb begin
    state_n = state;
    done_n  = 1'b0;
    err_n   = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          if (zero_len) done_n = 1'b1;
          else state_n = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (room1) state_n = ST_BUS;
      end
      ST_BUS: begin
        if (err_v) begin
          state_n = ST_IDLE;
          err_n   = 1'b1;
        end else if (ack_v) begin
          if (last) begin
            state_n = ST_IDLE;
            done_n  = 1'b1;
          end else if (!room2) begin
            state_n = ST_WAIT;
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      done    <= 1'b0;
      err_out <= 1'b0;
    end else begin
      state   <= state_n;
      done    <= done_n;
      err_out <= err_n;
    end
  end

  // R3
  stb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc && !ack && !err_in) |=> cyc);
  // R7
  err_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc && err_in) |=> (!cyc && err_out && !done));
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cyc);
  // R6
  pause_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc && ack && !err_in && !last && !room2) |=> !cyc);
endmodule

// File: rtl/wb_burst_fetch.sv
module wb_burst_fetch #(
  parameter int AW    = 32,
  parameter int LW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] buf_ptr_i,
  input  logic [LW-1:0] byte_len_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic          wb_cyc_o,
  output logic          wb_stb_o,
  output logic          wb_we_o,
  output logic [3:0]    wb_sel_o,
  output logic [AW-1:0] wb_adr_o,
  input  logic [31:0]   wb_dat_i,
  input  logic          wb_ack_i,
  input  logic          wb_err_i,
  input  logic          fifo_rd_en_i,
  output logic [31:0]   fifo_rd_data_o,
  output logic          fifo_empty_o
);
  import fetch_pkg::*;

  logic [1:0] rst_sync;
  logic       rst_int_n;
  logic       load, adv, push, last, zero, room1, room2, cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  fetch_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .start    (start_i),
    .zero_len (zero),
    .ack      (wb_ack_i),
    .err_in   (wb_err_i),
    .last     (last),
    .room1    (room1),
    .room2    (room2),
    .cyc      (cyc),
    .load     (load),
    .adv      (adv),
    .push     (push),
    .done     (done_o),
    .err_out  (err_o),
    .busy     (busy_o)
  );

  fetch_addr_seq #(.AW(AW), .LW(LW)) u_seq (
    .clk   (clk),
    .rst_n (rst_int_n),
    .load  (load),
    .adv   (adv),
    .base  (buf_ptr_i),
    .len   (byte_len_i),
    .adr   (wb_adr_o),
    .last  (last),
    .zero  (zero)
  );

  fetch_fifo #(.DW(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_int_n),
    .push  (push),
    .wdata (wb_dat_i),
    .pop   (fifo_rd_en_i),
    .rdata (fifo_rd_data_o),
    .empty (fifo_empty_o),
    .room1 (room1),
    .room2 (room2)
  );

  assign wb_cyc_o = cyc;
  assign wb_stb_o = cyc;
  assign wb_we_o  = 1'b0;
  assign wb_sel_o = 4'b1111;
endmodule

// File: tb/test_wb_burst_fetch.sv
`timescale 1ns/1ps
module test_wb_burst_fetch;
  localparam int AW = 32, LW = 16, DEPTH = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [AW-1:0] buf_ptr_i = '0;
  logic [LW-1:0] byte_len_i = '0;
  logic busy_o, done_o, err_o, wb_cyc_o, wb_stb_o, wb_we_o;
  logic [3:0] wb_sel_o;
  logic [AW-1:0] wb_adr_o;
  logic [31:0] wb_dat_i = '0;
  logic wb_ack_i = 1'b0, wb_err_i = 1'b0, fifo_rd_en_i = 1'b0;
  logic [31:0] fifo_rd_data_o;
  logic fifo_empty_o;

  always #2.5 clk = ~clk;

  wb_burst_fetch #(.AW(AW), .LW(LW), .DEPTH(DEPTH)) i_wb_burst_fetch (.*);

  int total = 0, bad = 0, cycles = 0;
  int ws = 0, wcnt = 0, pop_div = 1, pcnt = 0;
  logic [AW-1:0] err_adr = 32'hFFFF_FFF0;
  int acks = 0, cyc_rises = 0, dones = 0, errs = 0;
  logic cyc_prev = 1'b0;

  // reference model state
  int ms = 0;
  logic mdone = 0, merr = 0;
  logic [AW-1:0] madr = '0;
  int mrem = 0;
  logic [31:0] q[$];

  function automatic logic [31:0] mem_word(logic [AW-1:0] a);
    return {a[15:0] ^ 16'hA5C3, a[15:0]};
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms = 0; mdone = 0; merr = 0; mrem = 0; q.delete();
    end else begin
      automatic int fr = DEPTH - q.size();
      mdone = 0; merr = 0;
      if (fifo_rd_en_i && q.size() > 0) void'(q.pop_front());
      case (ms)
        0: if (start_i) begin
             if (byte_len_i == 0) mdone = 1;
             else begin
               madr = {buf_ptr_i[AW-1:2], 2'b00};
               mrem = (int'(byte_len_i) + 3) / 4;
               ms = 1;
             end
           end
        1: if (fr >= 1) ms = 2;
        default: begin
          if (wb_err_i) begin ms = 0; merr = 1; end
          else if (wb_ack_i) begin
            q.push_back(wb_dat_i);
            madr = madr + 4; mrem--;
            if (mrem == 0) begin ms = 0; mdone = 1; end
            else if (fr < 2) ms = 1;
          end
        end
      endcase
    end
  end

  // compare, then drive slave and read port
  always @(negedge clk) begin
    if (rst_n) begin
      chk(wb_cyc_o == (ms == 2), "R3", "cyc", wb_cyc_o, ms == 2);
      chk(wb_stb_o == (ms == 2), "R3", "stb", wb_stb_o, ms == 2);
      if (ms == 2) chk(wb_adr_o == madr, "R2", "adr", wb_adr_o, madr);
      chk(done_o == mdone, "R8", "done", done_o, mdone);
      chk(err_o == merr, "R7", "err", err_o, merr);
      chk(busy_o == (ms != 0), "R10", "busy", busy_o, ms != 0);
      chk(wb_we_o == 1'b0 && wb_sel_o == 4'hF, "R4", "we/sel", {wb_we_o, wb_sel_o}, 5'h0F);
      chk(fifo_empty_o == (q.size() == 0), "R5", "empty", fifo_empty_o, q.size() == 0);
      if (q.size() > 0)
        chk(fifo_rd_data_o == q[0], "R5", "rd_data", fifo_rd_data_o, q[0]);
      if (done_o) dones++;
      if (err_o) errs++;
      if (wb_cyc_o && !cyc_prev) cyc_rises++;
      cyc_prev = wb_cyc_o;
    end
    wb_ack_i = 0; wb_err_i = 0;
    if (wb_stb_o) begin
      if (wcnt >= ws) begin
        wcnt = 0;
        if (wb_adr_o == err_adr) wb_err_i = 1;
        else begin wb_ack_i = 1; wb_dat_i = mem_word(wb_adr_o); acks++; end
      end else wcnt++;
    end else wcnt = 0;
    pcnt = (pcnt + 1) % pop_div;
    fifo_rd_en_i = !fifo_empty_o && (pcnt == 0);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected<150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic fetch(logic [AW-1:0] p, int len);
    @(negedge clk);
    buf_ptr_i = p; byte_len_i = LW'(len); start_i = 1;
    acks = 0; cyc_rises = 0; dones = 0; errs = 0;
    @(negedge clk);
    start_i = 0;
    while (dones == 0 && errs == 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic drain();
    pop_div = 1;
    while (!fifo_empty_o) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!wb_cyc_o && !wb_stb_o && !busy_o && !done_o && !err_o && fifo_empty_o,
        "R1", "reset outputs", {wb_cyc_o, busy_o, done_o, err_o, fifo_empty_o}, 5'b00001);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R2 aligned, 4 words, no wait states
    ws = 0; fetch(32'h1000, 16);
    chk(acks == 4, "R2", "word count 16B", acks, 4);
    chk(cyc_rises == 1, "R3", "single cycle", cyc_rises, 1);
    drain();

    // R2 unaligned pointer, partial word, wait states
    ws = 2; fetch(32'h2003, 13);
    chk(acks == 4, "R2", "word count 13B", acks, 4);
    drain();

    // R11 start latency
    ws = 0;
    @(negedge clk);
    buf_ptr_i = 32'h4000; byte_len_i = 8; start_i = 1; dones = 0; errs = 0;
    @(negedge clk); start_i = 0;
    chk(!wb_cyc_o, "R11", "cyc one clock after start", wb_cyc_o, 0);
    @(negedge clk);
    chk(wb_cyc_o, "R11", "cyc two clocks after start", wb_cyc_o, 1);
    while (dones == 0) @(negedge clk);
    drain();

    // R6 back-pressure, slow drain
    pop_div = 5; ws = 0; fetch(32'h5000, 40);
    chk(acks == 10, "R6", "words under back-pressure", acks, 10);
    chk(cyc_rises > 1, "R6", "cycle reopened", cyc_rises, 2);
    drain();

    // R6 no drain at all until stall
    pop_div = 1000; ws = 1;
    fork
      fetch(32'h5800, 24);
      begin repeat (40) @(negedge clk); pop_div = 1; end
    join
    chk(acks == 6, "R6", "words after stall", acks, 6);
    drain();

    // R7 error mid-burst
    ws = 1; err_adr = 32'h3008; fetch(32'h3000, 32);
    chk(errs == 1 && dones == 0, "R7", "err pulse no done", {errs, dones}, 64'h1_0000_0000);
    chk(acks == 2, "R7", "words before err", acks, 2);
    err_adr = 32'hFFFF_FFF0;
    drain();

    // R9 zero length
    @(negedge clk);
    byte_len_i = 0; start_i = 1; dones = 0; cyc_rises = 0;
    @(negedge clk); start_i = 0;
    chk(done_o && !wb_cyc_o, "R9", "zero length done", {done_o, wb_cyc_o}, 2'b10);
    repeat (3) @(negedge clk);
    chk(cyc_rises == 0, "R9", "no bus cycle", cyc_rises, 0);

    // R10 start while busy ignored
    ws = 3;
    fork
      fetch(32'h6000, 20);
      begin
        repeat (6) @(negedge clk);
        buf_ptr_i = 32'h7700; byte_len_i = 4; start_i = 1;
        @(negedge clk); start_i = 0;
      end
    join
    chk(acks == 5, "R10", "original length kept", acks, 5);
    drain();

    // R8 single word
    ws = 0; fetch(32'h8004, 1);
    chk(acks == 1 && dones == 1, "R8", "one word done", {acks, dones}, 64'h1_0000_0001);
    drain();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule